// File: doc/BRIEF.md
# Inverted Page Table Translator

This block turns a 26-bit logical address from the processor into a physical DRAM address. The table is inverted: it holds one entry for each physical page. With the defaults there are 128 entries and 32 KB pages, which covers 4 MB. Each entry stores the logical page it currently serves, a valid flag and a two-bit protection code.

Every entry compares its logical page number against the incoming lower-half address in parallel. The entry that matches claims the access, and its index becomes the physical page number. The lower 32 MB of the space is translated; the upper 32 MB is open only to the supervisor. A miss, or a failed user-versus-supervisor permission check, raises an abort for that access.

Software fills the table with a supervisor store into the topmost eighth of the space. The new entry's contents are packed into the store address. The block has no data input, so the store's data takes no part.

The request is captured on a clock edge. Translation is combinational from that captured request, so the abort, the hit flag and the physical address are all valid during the following cycle.

Top module: `ipt_translator`

## Requirements
- R1: After reset every entry is invalid. With no request, `o_abort`, `o_hit` and `o_paddr` read 0, and any lower-half access misses.
- R2: A request sampled at edge N is reported during the cycle after edge N. For a lower-half address (bit 25 = 0), the logical page number is bits [24:15]. A valid entry i holding that page gives `o_hit`=1, `o_abort`=0 and `o_paddr` = {i[6:0], address bits [14:0]}.
- R3: A lower-half access that matches no valid entry gives `o_abort`=1, `o_hit`=0 and `o_paddr`=0.
- R4: Protection code 00 lets user-mode reads and writes through.
- R5: Protection code 01 lets user reads through and aborts user writes.
- R6: Protection codes 10 and 11 abort every user access. Supervisor accesses pass whatever the code is.
- R7: For an upper-half address (bit 25 = 1), a user access aborts. A supervisor access gives `o_abort`=0, `o_hit`=0 and `o_paddr`=0.
- R8: A supervisor write whose bits [25:23] are 111 programs one entry. The fields are packed in the address: entry index [6:0], protection [8:7], logical page [18:9] and valid [19]; bits [22:20] are ignored. The new contents apply from the very next request.
- R9: A user write to the programming region aborts and leaves the table unchanged. A supervisor read of that region does not program anything.
- R10: If several valid entries hold the same logical page, the lowest-numbered one is selected.
- R11: A cycle with `i_req_valid`=0 reports all outputs as 0 and does not change the table, whatever the other inputs carry.
- R12: Programming an entry with the valid bit 0 unmaps it, so a page it held is then served by another matching entry or misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_req_valid | input | 1 | Access present this cycle |
| i_req_addr | input | 26 | Logical address, or programming payload |
| i_req_write | input | 1 | 1 = store, 0 = load |
| i_req_supv | input | 1 | 1 = supervisor mode |
| o_abort | output | 1 | Access refused: miss, protection, or user access to the upper half |
| o_hit | output | 1 | Translation granted |
| o_paddr | output | 22 | Physical address {page, offset} when `o_hit` is 1, else 0 |

## Verification
The assertions assume that reset is held from time zero through at least the first clock edge, and that the request inputs never carry unknown values once reset is released. They also assume that each request's effect appears exactly one edge later, so the captured-request checks can pair a request with the following cycle. The bench keeps to this by driving known values from the start, holding reset for several cycles, and changing inputs only on the falling edge. The lowest-index and claim checks relate the reported page to the per-entry match lines; randomised traffic limits logical pages to a small range so that duplicates and hits occur often.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  // Entry protection codes
  typedef enum logic [1:0] {
    PROT_USER_RW = 2'b00,
    PROT_USER_RO = 2'b01,
    PROT_SUPV_A  = 2'b10,
    PROT_SUPV_B  = 2'b11
  } prot_e;

  localparam int DEF_ADDR_W    = 26;
  localparam int DEF_PAGE_W    = 15;
  localparam int DEF_NUM_PAGES = 128;
endpackage

// File: rtl/ipt_entry.sv
// One table entry: owns a physical page and claims a matching logical page.
module ipt_entry
  import ipt_pkg::*;
#(
  parameter int LPN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_valid,
  input  logic [LPN_W-1:0] wr_lpn,
  input  prot_e            wr_prot,
  input  logic [LPN_W-1:0] lk_lpn,
  output logic             match,
  output prot_e            prot
);
  logic             valid_q;
  logic [LPN_W-1:0] lpn_q;
  prot_e            prot_q;

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= 1'b0;
    else if (wr_en) valid_q <= wr_valid;
  end

  // Payload fields need no reset: the valid flag guards them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      lpn_q  <= wr_lpn;
      prot_q <= wr_prot;
    end
  end

  assign match = valid_q && (lpn_q == lk_lpn);
  assign prot  = prot_q;
endmodule

// File: rtl/ipt_prio.sv
// Lowest-index-wins selector over the entry match lines.
module ipt_prio #(
  parameter int N     = 128,
  parameter int IDX_W = 7
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/ipt_perm.sv
// Privilege check on the claiming entry's protection code.
module ipt_perm
  import ipt_pkg::*;
(
  input  logic  supv,
  input  logic  write,
  input  prot_e prot,
  output logic  deny
);
  always_comb begin
    if (supv) begin
      deny = 1'b0;
    end else begin
      unique case (prot)
        PROT_USER_RW:  deny = 1'b0;
        PROT_USER_RO:  deny = write;
        default:       deny = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ipt_translator.sv
module ipt_translator
  import ipt_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int PAGE_W    = DEF_PAGE_W,
  parameter int NUM_PAGES = DEF_NUM_PAGES,
  localparam int IDX_W    = $clog2(NUM_PAGES),
  localparam int PA_W     = IDX_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_req_valid,
  input  logic [ADDR_W-1:0] i_req_addr,
  input  logic              i_req_write,
  input  logic              i_req_supv,
  output logic              o_abort,
  output logic              o_hit,
  output logic [PA_W-1:0]   o_paddr
);
  localparam int LPN_W       = ADDR_W - 1 - PAGE_W;
  localparam int PRG_PROT_LO = IDX_W;
  localparam int PRG_LPN_LO  = IDX_W + 2;
  localparam int PRG_VLD_BIT = PRG_LPN_LO + LPN_W;

  // Captured request
  logic              r_valid;
  logic [ADDR_W-1:0] r_addr;
  logic              r_write;
  logic              r_supv;

  always_ff @(posedge clk) begin
    if (rst) r_valid <= 1'b0;
    else     r_valid <= i_req_valid;
  end

  always_ff @(posedge clk) begin
    r_addr  <= i_req_addr;
    r_write <= i_req_write;
    r_supv  <= i_req_supv;
  end

  logic upper_half;
  logic prog_hit;
  logic [LPN_W-1:0] lk_lpn;

  assign upper_half = r_addr[ADDR_W-1];
  assign prog_hit   = r_valid && r_write && r_supv && (r_addr[ADDR_W-1 -: 3] == 3'b111);
  assign lk_lpn     = r_addr[ADDR_W-2 -: LPN_W];

  // Entry array
  logic [NUM_PAGES-1:0] ent_match;
  prot_e                ent_prot [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
    ipt_entry #(.LPN_W(LPN_W)) u_ent (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (prog_hit && (r_addr[IDX_W-1:0] == IDX_W'(g))),
      .wr_valid (r_addr[PRG_VLD_BIT]),
      .wr_lpn   (r_addr[PRG_LPN_LO +: LPN_W]),
      .wr_prot  (prot_e'(r_addr[PRG_PROT_LO +: 2])),
      .lk_lpn   (lk_lpn),
      .match    (ent_match[g]),
      .prot     (ent_prot[g])
    );
  end

  logic             any_match;
  logic [IDX_W-1:0] win_idx;

  ipt_prio #(.N(NUM_PAGES), .IDX_W(IDX_W)) u_prio (
    .req (ent_match),
    .any (any_match),
    .idx (win_idx)
  );

  logic perm_deny;

  ipt_perm u_perm (
    .supv  (r_supv),
    .write (r_write),
    .prot  (ent_prot[win_idx]),
    .deny  (perm_deny)
  );

  always_comb begin
    o_abort = 1'b0;
    o_hit   = 1'b0;
    o_paddr = '0;
    if (r_valid) begin
      if (upper_half) begin
        o_abort = !r_supv;
      end else if (!any_match || perm_deny) begin
        o_abort = 1'b1;
      end else begin
        o_hit   = 1'b1;
        o_paddr = {win_idx, r_addr[PAGE_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/ipt_translator_chk.sv
module ipt_translator_chk #(
  parameter int ADDR_W    = 26,
  parameter int PAGE_W    = 15,
  parameter int NUM_PAGES = 128,
  parameter int IDX_W     = 7,
  parameter int PA_W      = 22
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 i_req_valid,
  input logic [ADDR_W-1:0]    i_req_addr,
  input logic                 i_req_supv,
  input logic                 o_abort,
  input logic                 o_hit,
  input logic [PA_W-1:0]      o_paddr,
  input logic [NUM_PAGES-1:0] ent_match
);
  logic lk_lower;
  always_ff @(posedge clk) begin
    if (rst) lk_lower <= 1'b0;
    else     lk_lower <= i_req_valid && !i_req_addr[ADDR_W-1];
  end

  logic [IDX_W-1:0]     ppn;
  logic [NUM_PAGES-1:0] below;
  assign ppn = o_paddr[PA_W-1:PAGE_W];
  always_comb begin
    for (int i = 0; i < NUM_PAGES; i++) below[i] = ent_match[i] && (i < int'(ppn));
  end

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !i_req_valid |=> (!o_abort && !o_hit && o_paddr == '0));

  p_upper_user_r7: assert property (@(posedge clk) disable iff (rst)
    (i_req_valid && !i_req_supv && i_req_addr[ADDR_W-1]) |=> (o_abort && !o_hit));

  p_upper_supv_r7: assert property (@(posedge clk) disable iff (rst)
    (i_req_valid && i_req_supv && i_req_addr[ADDR_W-1]) |=> (!o_abort && !o_hit));

  p_miss_abort_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_lower && ent_match == '0) |-> (o_abort && !o_hit));

  p_hit_claims_r2: assert property (@(posedge clk) disable iff (rst)
    o_hit |-> ent_match[ppn]);

  p_lowest_wins_r10: assert property (@(posedge clk) disable iff (rst)
    o_hit |-> (below == '0));
endmodule

bind ipt_translator ipt_translator_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .PA_W(PA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .i_req_valid (i_req_valid),
  .i_req_addr  (i_req_addr),
  .i_req_supv  (i_req_supv),
  .o_abort     (o_abort),
  .o_hit       (o_hit),
  .o_paddr     (o_paddr),
  .ent_match   (ent_match)
);

// File: tb/test_ipt_translator.sv
module test_ipt_translator;
  localparam int NP = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v = 1'b0, w = 1'b0, s = 1'b0;
  logic [25:0] a = '0;
  logic        o_abort, o_hit;
  logic [21:0] o_paddr;

  ipt_translator i_ipt_translator (
    .clk(clk), .rst(rst), .i_req_valid(v), .i_req_addr(a),
    .i_req_write(w), .i_req_supv(s),
    .o_abort(o_abort), .o_hit(o_hit), .o_paddr(o_paddr)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference table
  bit m_valid [NP];
  int m_lpn   [NP];
  int m_prot  [NP];

  bit          pend = 1'b0;
  bit          e_abort, e_hit;
  logic [21:0] e_pa;
  string       e_tag;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      cmp(e_tag, "abort", 32'(o_abort), 32'(e_abort));
      cmp(e_tag, "hit",   32'(o_hit),   32'(e_hit));
      cmp(e_tag, "paddr", 32'(o_paddr), 32'(e_pa));
    end
  endtask

  function automatic logic [25:0] prog(int idx, int lpn, int prot, bit vld);
    return {3'b111, 3'b000, vld, 10'(lpn), 2'(prot), 7'(idx)};
  endfunction

  function automatic logic [25:0] uaddr(int lpn, int off);
    return {1'b0, 10'(lpn), 15'(off)};
  endfunction

  task automatic issue(bit vv, bit ww, bit ss, logic [25:0] aa, string tag);
    int lpn, found;
    @(negedge clk);
    check_pending();
    e_abort = 1'b0; e_hit = 1'b0; e_pa = '0;
    if (vv) begin
      if (aa[25]) begin
        e_abort = !ss;
        if (ss && ww && aa[24:23] == 2'b11) begin
          m_valid[aa[6:0]] = aa[19];
          m_lpn[aa[6:0]]   = int'(aa[18:9]);
          m_prot[aa[6:0]]  = int'(aa[8:7]);
        end
      end else begin
        lpn = int'(aa[24:15]);
        found = -1;
        for (int i = 0; i < NP; i++)
          if (found < 0 && m_valid[i] && m_lpn[i] == lpn) found = i;
        if (found < 0) e_abort = 1'b1;
        else if (!ss && (m_prot[found] >= 2 || (m_prot[found] == 1 && ww))) e_abort = 1'b1;
        else begin
          e_hit = 1'b1;
          e_pa  = {7'(found), aa[14:0]};
        end
      end
    end
    v = vv; w = ww; s = ss; a = aa;
    pend = 1'b1; e_tag = tag;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NP; i++) begin m_valid[i] = 0; m_lpn[i] = 0; m_prot[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    cmp("R1", "abort", 32'(o_abort), 0);
    cmp("R1", "hit",   32'(o_hit),   0);
    cmp("R1", "paddr", 32'(o_paddr), 0);
    issue(1, 0, 0, uaddr(5, 0), "R1");
    issue(1, 0, 1, uaddr(0, 7), "R1");

    // R8 / R2 / R4: program and use back-to-back
    issue(1, 1, 1, prog(5, 'h12, 0, 1), "R8");
    issue(1, 0, 0, uaddr('h12, 'h1234), "R2");
    issue(1, 1, 0, uaddr('h12, 'h7fff), "R4");

    // R5 read-only page
    issue(1, 1, 1, prog(20, 'h33, 1, 1), "R8");
    issue(1, 0, 0, uaddr('h33, 'h10), "R5");
    issue(1, 1, 0, uaddr('h33, 'h10), "R5");
    issue(1, 1, 1, uaddr('h33, 'h20), "R6");

    // R6 supervisor-only, top entry
    issue(1, 1, 1, prog(127, 'h3ff, 2, 1), "R8");
    issue(1, 0, 0, uaddr('h3ff, 1), "R6");
    issue(1, 0, 1, uaddr('h3ff, 1), "R6");
    issue(1, 1, 1, prog(0, 'h1, 3, 1), "R8");
    issue(1, 1, 0, uaddr('h1, 2), "R6");
    issue(1, 1, 1, uaddr('h1, 2), "R6");

    // R3 miss
    issue(1, 0, 0, uaddr('h200, 0), "R3");

    // R7 upper half
    issue(1, 0, 0, 26'h3000000, "R7");
    issue(1, 1, 1, 26'h2000010, "R7");

    // R9 user store / supervisor load to programming region
    issue(1, 1, 0, prog(30, 'h44, 0, 1), "R9");
    issue(1, 0, 1, prog(31, 'h44, 0, 1), "R9");
    issue(1, 0, 1, uaddr('h44, 0), "R9");

    // R10 duplicates, R12 unmap
    issue(1, 1, 1, prog(9, 'h50, 0, 1), "R8");
    issue(1, 1, 1, prog(3, 'h50, 0, 1), "R8");
    issue(1, 0, 0, uaddr('h50, 'h55), "R10");
    issue(1, 1, 1, prog(3, 'h50, 0, 0), "R12");
    issue(1, 0, 0, uaddr('h50, 'h55), "R12");

    // R11 idle with a programming payload on the bus; bits [22:20] set (R8 ignored)
    issue(0, 1, 1, prog(40, 'h60, 0, 1), "R11");
    issue(1, 0, 1, uaddr('h60, 0), "R11");
    issue(1, 1, 1, prog(41, 'h61, 0, 1) | 26'h0700000, "R8");
    issue(1, 0, 0, uaddr('h61, 3), "R8");

    // Mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      if (r < 5)
        issue(0, 1'($urandom), 1'($urandom), 26'($urandom), "R11");
      else if (r < 30)
        issue(1, 1, 1, prog($urandom_range(0, NP-1), $urandom_range(0, 31),
                            $urandom_range(0, 3), ($urandom_range(0, 9) != 0)), "R8");
      else if (r < 38)
        issue(1, 1'($urandom), 1'($urandom), {1'b1, 25'($urandom)}, "R7");
      else
        issue(1, 1'($urandom), 1'($urandom),
              uaddr($urandom_range(0, 31), $urandom_range(0, 32767)), "R2 R5 R10");
    end

    issue(0, 0, 0, '0, "R11");
    @(negedge clk);
    check_pending();
    finish_run();
  end
endmodule